// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block listens passively to the command pins of a DDR SDRAM interface. It never drives the bus. On every rising clock it samples the clock-enable, chip-select, row/column strobes, write enable, bank and address pins. It classifies the command and reports it one cycle later, together with the bank, row and column fields that apply to that command.

Behind the report it models the device. It tracks which of the banks hold an open row, and which row that is. It keeps shadow copies of the base and extended mode registers. It follows the read or write burst in flight, so that it knows when an auto-precharge takes effect and when a burst terminate is allowed.

Any command that the device state makes illegal produces a one-cycle error pulse on its own bit and also sets a matching sticky bit. A flagged bank or burst command is otherwise ignored by the model. A verification environment or a debug probe attaches this block to a memory controller's output and watches the error vector.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With the strobes read as {cs_n, ras_n, cas_n, we_n}, the commands decode as follows. Any pattern with cs_n high, and 0111, both give NOP (code 0). 0011 is ACTIVE (1), 0101 is READ (2), 0100 is WRITE (3), 0110 is BURST TERMINATE (4) and 0010 is PRECHARGE (5). 0001 is AUTO REFRESH (6) when cke is high and SELF REFRESH entry (7) when cke is low. 0000 is LOAD MODE (8). The code sampled at one rising edge appears on cmd_code after that edge and holds for one cycle.
- R2: A NOP or deselected cycle changes no bank state and neither mode register.
- R3: An ACTIVE to a closed bank opens that bank (bank_open bit = bank number) and stores addr as its row. The row appears in bank_row[bank*13 +: 13] and on cmd_row.
- R4: READ and WRITE report cmd_bank, cmd_col = addr[8:0] and cmd_ap = addr[10]. With addr[10] high, the burst's bank closes at the edge BURST_LEN/2 cycles after the command's edge, unless another READ or WRITE is accepted at that edge.
- R5: PRECHARGE with addr[10] low closes only the bank on ba. With addr[10] high it closes every bank, whatever ba holds.
- R6: With cke low, any command other than NOP or the refresh pattern sets error bit 5, is reported as NOP and changes nothing.
- R7: LOAD MODE with ba=0 writes the base mode register and with ba=1 writes the extended one. Any other ba value sets error bit 6 and writes neither.
- R8: dll_off follows extended bit 0 and drv_reduced follows extended bit 1. A write of the extended register with any of bits 12..2 set sets error bit 3, and the value is still stored.
- R9: BURST TERMINATE is legal only while a READ burst without auto-precharge is running. A legal terminate ends that burst. Otherwise it sets error bit 2, including during an auto-precharge READ burst, during a WRITE burst, or with no burst running.
- R10: A base mode write whose latency field addr[6:4] is neither 010 (2 clocks) nor 110 (2.5 clocks), or whose burst-length field addr[2:0] is not 010 (length 4), sets error bit 4.
- R11: A READ or WRITE to a closed bank sets error bit 0, and an ACTIVE to an open bank sets error bit 1. Neither command changes any bank, row or burst state.
- R12: err_pulse bits are valid for one cycle with the report. Each err_sticky bit is set when its pulse bit is set and stays set until reset.
- R13: While reset is applied, and for two cycles after its release, all banks are closed, both mode shadows are zero and every report and error output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address / op-code bus |
| cmd_code | output | 4 | Decoded command code (R1) |
| cmd_bank | output | 2 | Bank of ACTIVE, READ, WRITE or single-bank PRECHARGE |
| cmd_row | output | 13 | Row of an ACTIVE |
| cmd_col | output | 9 | Column of a READ or WRITE |
| cmd_ap | output | 1 | addr[10] of READ, WRITE or PRECHARGE |
| err_pulse | output | 7 | One-cycle error flags |
| err_sticky | output | 7 | Accumulated error flags |
| bank_open | output | 4 | Open flag per bank |
| bank_row | output | 52 | Stored row per bank, bank 0 in the low bits |
| mr_base | output | 13 | Base mode register shadow |
| mr_ext | output | 13 | Extended mode register shadow |
| dll_off | output | 1 | Extended bit 0 (DLL disabled) |
| drv_reduced | output | 1 | Extended bit 1 (reduced drive) |

## Verification
The bench targets the auto-precharge close edge. A burst counter that is off by one would leave the bank open a cycle too long or shut it early, and the next READ would then be wrongly flagged. Burst terminate is probed right after a plain READ, once more after the burst was terminated, during an auto-precharge READ and during a WRITE. A monitor that tracked only "a burst is running" would accept the last two. The bench also drives all-bank precharge with a bank field that points elsewhere, and an ACTIVE with cke low. A decoder that trusted ba, or ignored cke, would then leave banks open. A long random command stream checks that every flagged command leaves rows and burst state untouched.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_BST  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_REF  = 4'd6,
    CMD_SREF = 4'd7,
    CMD_LMR  = 4'd8
  } ddr_cmd_e;

  // error vector layout
  localparam int ERR_W      = 7;
  localparam int E_CLOSED   = 0;
  localparam int E_REOPEN   = 1;
  localparam int E_BST      = 2;
  localparam int E_EXT_RSVD = 3;
  localparam int E_MODE     = 4;
  localparam int E_CKE      = 5;
  localparam int E_MR_SEL   = 6;

  // base mode register fields that the checker decodes
  localparam int BL_LSB = 0;
  localparam int CL_LSB = 4;
  localparam int FLD_W  = 3;
  localparam logic [FLD_W-1:0] CL_TWO  = 3'b010;
  localparam logic [FLD_W-1:0] CL_TWO5 = 3'b110;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic     cke,
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output ddr_cmd_e cmd,
  output logic     cke_err
);

  ddr_cmd_e raw;

  always_comb begin
    raw = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  raw = CMD_ACT;
        3'b101:  raw = CMD_RD;
        3'b100:  raw = CMD_WR;
        3'b110:  raw = CMD_BST;
        3'b010:  raw = CMD_PRE;
        3'b001:  raw = CMD_REF;
        3'b000:  raw = CMD_LMR;
        default: raw = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    cmd     = raw;
    cke_err = 1'b0;
    if (!cke) begin
      if (raw == CMD_REF) begin
        cmd = CMD_SREF;
      end else if (raw != CMD_NOP) begin
        cmd     = CMD_NOP;
        cke_err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ddr_cmd_e                   cmd,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           row,
  input  logic                       ap,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic                       err_closed,
  output logic                       err_reopen,
  output logic                       err_bst
);

  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int CNT_W     = $clog2(BURST_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BA_W-1:0]  bbank_q, bbank_d;
  logic             bap_q, bap_d;
  logic             brd_q, brd_d;
  logic             burst_en;
  logic             is_rw, rw_ok, act_ok, bst_ok, ap_close;

  always_comb begin
    is_rw      = (cmd == CMD_RD) || (cmd == CMD_WR);
    rw_ok      = is_rw && bank_open[ba];
    act_ok     = (cmd == CMD_ACT) && !bank_open[ba];
    bst_ok     = (cnt_q != '0) && brd_q && !bap_q;
    err_closed = is_rw && !bank_open[ba];
    err_reopen = (cmd == CMD_ACT) && bank_open[ba];
    err_bst    = (cmd == CMD_BST) && !bst_ok;
    ap_close   = bap_q && (cnt_q == CNT_W'(1)) && !rw_ok;

    cnt_d   = (cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
    bbank_d = bbank_q;
    bap_d   = bap_q;
    brd_d   = brd_q;
    if (rw_ok) begin
      cnt_d   = CNT_W'(BURST_CYC);
      bbank_d = ba;
      bap_d   = ap;
      brd_d   = (cmd == CMD_RD);
    end else if ((cmd == CMD_BST) && bst_ok) begin
      cnt_d = '0;
    end
    burst_en = (cnt_q != '0) || rw_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bbank_q <= '0;
      bap_q   <= 1'b0;
      brd_q   <= 1'b0;
    end else if (burst_en) begin
      cnt_q   <= cnt_d;
      bbank_q <= bbank_d;
      bap_q   <= bap_d;
      brd_q   <= brd_d;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q, open_d;
    logic             row_we, hit;
    logic [ROW_W-1:0] row_q;

    always_comb begin
      hit    = (ba == BA_W'(b));
      row_we = act_ok && hit;
      open_d = open_q;
      if (ap_close && (bbank_q == BA_W'(b))) open_d = 1'b0;
      if (row_we) open_d = 1'b1;
      if ((cmd == CMD_PRE) && (ap || hit)) open_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q <= 1'b0;
      else        open_q <= open_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_we) row_q <= row;
    end

    assign bank_open[b]                  = open_q;
    assign bank_row[b*ROW_W +: ROW_W]    = row_q;
  end

endmodule

// File: rtl/ddr_mode_shadow.sv
module ddr_mode_shadow
  import ddr_mon_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int OP_W      = 13,
  parameter int BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ddr_cmd_e        cmd,
  input  logic [BA_W-1:0] ba,
  input  logic [OP_W-1:0] addr,
  output logic [OP_W-1:0] mr_base,
  output logic [OP_W-1:0] mr_ext,
  output logic            err_rsvd,
  output logic            err_mode,
  output logic            err_sel
);

  localparam logic [FLD_W-1:0] BL_CODE = FLD_W'($clog2(BURST_LEN));

  logic             is_lmr, base_we, ext_we;
  logic [FLD_W-1:0] cl_f, bl_f;

  always_comb begin
    is_lmr   = (cmd == CMD_LMR);
    base_we  = is_lmr && (ba == BA_W'(0));
    ext_we   = is_lmr && (ba == BA_W'(1));
    err_sel  = is_lmr && !base_we && !ext_we;
    cl_f     = addr[CL_LSB +: FLD_W];
    bl_f     = addr[BL_LSB +: FLD_W];
    err_mode = base_we && (!((cl_f == CL_TWO) || (cl_f == CL_TWO5)) || (bl_f != BL_CODE));
    err_rsvd = ext_we && (addr[OP_W-1:2] != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mr_base <= '0;
    else if (base_we) mr_base <= addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mr_ext <= '0;
    else if (ext_we) mr_ext <= addr;
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int ROW_W     = 13,
  parameter  int COL_W     = 9,
  parameter  int AP_BIT    = 10,
  parameter  int BURST_LEN = 4,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmd_code,
  output logic [BA_W-1:0]            cmd_bank,
  output logic [ROW_W-1:0]           cmd_row,
  output logic [COL_W-1:0]           cmd_col,
  output logic                       cmd_ap,
  output logic [ERR_W-1:0]           err_pulse,
  output logic [ERR_W-1:0]           err_sticky,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic [ROW_W-1:0]           mr_base,
  output logic [ROW_W-1:0]           mr_ext,
  output logic                       dll_off,
  output logic                       drv_reduced
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ddr_cmd_e cmd;
  logic     cke_err;
  logic     ap;
  logic     err_closed, err_reopen, err_bst, err_rsvd, err_mode, err_sel;

  assign ap = addr[AP_BIT];

  ddr_cmd_decode u_decode (
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .cmd     (cmd),
    .cke_err (cke_err)
  );

  ddr_bank_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W),
    .ROW_W     (ROW_W),
    .BURST_LEN (BURST_LEN)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd        (cmd),
    .ba         (ba),
    .row        (addr),
    .ap         (ap),
    .bank_open  (bank_open),
    .bank_row   (bank_row),
    .err_closed (err_closed),
    .err_reopen (err_reopen),
    .err_bst    (err_bst)
  );

  ddr_mode_shadow #(
    .BA_W      (BA_W),
    .OP_W      (ROW_W),
    .BURST_LEN (BURST_LEN)
  ) u_mode (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd      (cmd),
    .ba       (ba),
    .addr     (addr),
    .mr_base  (mr_base),
    .mr_ext   (mr_ext),
    .err_rsvd (err_rsvd),
    .err_mode (err_mode),
    .err_sel  (err_sel)
  );

  assign dll_off     = mr_ext[0];
  assign drv_reduced = mr_ext[1];

  // report stage
  logic [BA_W-1:0]  bank_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic             ap_d;
  logic [ERR_W-1:0] err_d;

  always_comb begin
    bank_d = '0;
    row_d  = '0;
    col_d  = '0;
    ap_d   = 1'b0;
    case (cmd)
      CMD_ACT: begin
        bank_d = ba;
        row_d  = addr;
      end
      CMD_RD, CMD_WR: begin
        bank_d = ba;
        col_d  = addr[COL_W-1:0];
        ap_d   = ap;
      end
      CMD_PRE: begin
        bank_d = ap ? '0 : ba;
        ap_d   = ap;
      end
      default: ;
    endcase

    err_d             = '0;
    err_d[E_CLOSED]   = err_closed;
    err_d[E_REOPEN]   = err_reopen;
    err_d[E_BST]      = err_bst;
    err_d[E_EXT_RSVD] = err_rsvd;
    err_d[E_MODE]     = err_mode;
    err_d[E_CKE]      = cke_err;
    err_d[E_MR_SEL]   = err_sel;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_code   <= 4'd0;
      cmd_bank   <= '0;
      cmd_row    <= '0;
      cmd_col    <= '0;
      cmd_ap     <= 1'b0;
      err_pulse  <= '0;
      err_sticky <= '0;
    end else begin
      cmd_code   <= cmd;
      cmd_bank   <= bank_d;
      cmd_row    <= row_d;
      cmd_col    <= col_d;
      cmd_ap     <= ap_d;
      err_pulse  <= err_d;
      err_sticky <= err_sticky | err_d;
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_ok,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic [ROW_W-1:0]     addr,
  input logic [3:0]           cmd_code,
  input logic [ERR_W-1:0]     err_pulse,
  input logic [ERR_W-1:0]     err_sticky,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [ROW_W-1:0]     mr_base,
  input logic [ROW_W-1:0]     mr_ext
);

  logic [2:0] strb;
  assign strb = {ras_n, cas_n, we_n};

  // R2: a deselected cycle leaves both mode shadows alone
  a_r2_desel_keeps_mode: assert property (@(posedge clk) disable iff (!rst_ok)
    cs_n |=> ($stable(mr_base) && $stable(mr_ext)));

  // R3: ACTIVE to a closed bank opens it
  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_ok)
    (cke && !cs_n && strb == 3'b011 && !bank_open[ba]) |=> bank_open[$past(ba)]);

  // R5: all-bank precharge closes everything
  a_r5_pre_all: assert property (@(posedge clk) disable iff (!rst_ok)
    (cke && !cs_n && strb == 3'b010 && addr[AP_BIT]) |=> (bank_open == '0));

  // R6: commands with cke low are rejected
  a_r6_cke_low: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cke && !cs_n && strb != 3'b111 && strb != 3'b001)
      |=> (err_pulse[E_CKE] && cmd_code == 4'd0));

  // R8: reserved extended bits flagged
  a_r8_ext_rsvd: assert property (@(posedge clk) disable iff (!rst_ok)
    (cke && !cs_n && strb == 3'b000 && ba == BA_W'(1) && addr[ROW_W-1:2] != '0)
      |=> err_pulse[E_EXT_RSVD]);

  // R9: terminate error only reported with a terminate command
  a_r9_bst_code: assert property (@(posedge clk) disable iff (!rst_ok)
    err_pulse[E_BST] |-> (cmd_code == 4'd4));

  // R12: sticky covers every pulse and never drops
  a_r12_sticky_covers: assert property (@(posedge clk) disable iff (!rst_ok)
    ((err_pulse & ~err_sticky) == '0));

  a_r12_sticky_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .AP_BIT    (AP_BIT),
  .BA_W      (BA_W)
) chk_i (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .addr       (addr),
  .cmd_code   (cmd_code),
  .err_pulse  (err_pulse),
  .err_sticky (err_sticky),
  .bank_open  (bank_open),
  .mr_base    (mr_base),
  .mr_ext     (mr_ext)
);

// File: tb/ddr_cmd_monitor_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_tb_top;

  localparam [3:0] P_NOP = 4'b0111, P_DES = 4'b1111, P_ACT = 4'b0011,
                   P_RD  = 4'b0101, P_WR  = 4'b0100, P_BST = 4'b0110,
                   P_PRE = 4'b0010, P_REF = 4'b0001, P_LMR = 4'b0000;
  localparam int BCYC = 2;

  logic        clk, rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [8:0]  cmd_col;
  logic        cmd_ap;
  logic [6:0]  err_pulse, err_sticky;
  logic [3:0]  bank_open;
  logic [51:0] bank_row;
  logic [12:0] mr_base, mr_ext;
  logic        dll_off, drv_reduced;

  int checks = 0;
  int fails  = 0;

  ddr_cmd_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .err_pulse(err_pulse),
    .err_sticky(err_sticky), .bank_open(bank_open), .bank_row(bank_row),
    .mr_base(mr_base), .mr_ext(mr_ext), .dll_off(dll_off),
    .drv_reduced(drv_reduced)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  bit       m_open[4];
  int       m_row[4];
  int       m_cnt, m_bbank;
  bit       m_bap, m_brd;
  int       m_base, m_ext;
  int       e_code, e_bank, e_row, e_col, e_ap;
  bit [6:0] e_err, e_sticky;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit [2:0] s;
    int  b, oc, obank;
    bit  obap, rw_ok;
    bit  old_open[4];
    s  = {ras_n, cas_n, we_n};
    b  = ba;
    e_code = 0; e_err = '0; e_bank = 0; e_row = 0; e_col = 0; e_ap = 0;
    if (!cs_n) begin
      if      (s == 3'b011) e_code = 1;
      else if (s == 3'b101) e_code = 2;
      else if (s == 3'b100) e_code = 3;
      else if (s == 3'b110) e_code = 4;
      else if (s == 3'b010) e_code = 5;
      else if (s == 3'b001) e_code = 6;
      else if (s == 3'b000) e_code = 8;
    end
    if (!cke) begin
      if (e_code == 6) e_code = 7;
      else if (e_code != 0) begin e_code = 0; e_err[5] = 1; end
    end
    foreach (old_open[i]) old_open[i] = m_open[i];
    oc = m_cnt; obank = m_bbank; obap = m_bap; rw_ok = 0;
    m_cnt = (oc > 0) ? oc - 1 : 0;
    case (e_code)
      1: begin
        e_bank = b; e_row = addr;
        if (old_open[b]) e_err[1] = 1;
        else begin m_open[b] = 1; m_row[b] = addr; end
      end
      2, 3: begin
        e_bank = b; e_col = addr[8:0]; e_ap = addr[10];
        if (!old_open[b]) e_err[0] = 1;
        else begin
          rw_ok = 1; m_cnt = BCYC; m_bbank = b; m_bap = addr[10]; m_brd = (e_code == 2);
        end
      end
      4: begin
        if (oc > 0 && m_brd && !m_bap) m_cnt = 0;
        else e_err[2] = 1;
      end
      5: begin
        e_ap = addr[10];
        if (addr[10]) foreach (m_open[i]) m_open[i] = 0;
        else begin e_bank = b; m_open[b] = 0; end
      end
      8: begin
        if (b == 0) begin
          m_base = addr;
          if ((addr[6:4] != 3'b010 && addr[6:4] != 3'b110) || addr[2:0] != 3'b010) e_err[4] = 1;
        end else if (b == 1) begin
          m_ext = addr;
          if (addr[12:2] != 0) e_err[3] = 1;
        end else e_err[6] = 1;
      end
      default: ;
    endcase
    if (!rw_ok && oc == 1 && obap) m_open[obank] = 0;
    e_sticky |= e_err;
  endtask

  task automatic compare_all();
    chk("R1 cmd_code", cmd_code, e_code);
    chk("R4 cmd_bank", cmd_bank, e_bank);
    chk("R3 cmd_row", cmd_row, e_row);
    chk("R4 cmd_col", cmd_col, e_col);
    chk("R4 cmd_ap", cmd_ap, e_ap);
    for (int i = 0; i < 4; i++) begin
      chk("R3 bank_open", bank_open[i], m_open[i]);
      chk("R3 bank_row", bank_row[i*13 +: 13], m_row[i]);
    end
    chk("R7 mr_base", mr_base, m_base);
    chk("R7 mr_ext", mr_ext, m_ext);
    chk("R8 dll_off", dll_off, m_ext & 1);
    chk("R8 drv_reduced", drv_reduced, (m_ext >> 1) & 1);
    chk("R12 err_pulse", err_pulse, e_err);
    chk("R12 err_sticky", err_sticky, e_sticky);
  endtask

  task automatic step(input bit k, input logic [3:0] p, input logic [1:0] b, input logic [12:0] a);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    foreach (m_open[i]) begin m_open[i] = 0; m_row[i] = 0; end
    m_cnt = 0; m_bbank = 0; m_bap = 0; m_brd = 0; m_base = 0; m_ext = 0;
    e_code = 0; e_bank = 0; e_row = 0; e_col = 0; e_ap = 0; e_err = '0; e_sticky = '0;
    rst_n = 1'b0; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = P_DES; ba = 2'd0; addr = '0;
    // R13: reset state, even with commands on the bus
    repeat (2) @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = P_ACT;
    @(negedge clk);
    chk("R13 bank_open", bank_open, 0);
    chk("R13 cmd_code", cmd_code, 0);
    chk("R13 err_sticky", err_sticky, 0);
    chk("R13 mr_ext", mr_ext, 0);
    {cs_n, ras_n, cas_n, we_n} = P_DES;
    rst_n = 1'b1;
    repeat (3) step(1, P_NOP, 0, 0);

    // R2: deselect/NOP changes nothing
    step(1, P_DES, 2, 13'h1FFF);
    chk("R2 bank_open after deselect", bank_open, 0);
    chk("R2 mr_base after deselect", mr_base, 0);

    // R10 / R7: base mode writes
    step(1, P_LMR, 0, 13'h022);
    chk("R10 CL2 BL4 accepted", err_pulse, 0);
    chk("R7 base stored", mr_base, 13'h022);
    step(1, P_LMR, 0, 13'h032);
    chk("R10 CL3 flagged", err_pulse[4], 1);
    step(1, P_LMR, 0, 13'h023);
    chk("R10 BL8 flagged", err_pulse[4], 1);
    step(1, P_LMR, 0, 13'h062);
    chk("R10 CL2.5 accepted", err_pulse, 0);

    // R8 / R7: extended register
    step(1, P_LMR, 1, 13'h003);
    chk("R8 dll_off", dll_off, 1);
    chk("R8 drv_reduced", drv_reduced, 1);
    step(1, P_LMR, 1, 13'h001);
    chk("R8 drive normal", drv_reduced, 0);
    step(1, P_LMR, 1, 13'h008);
    chk("R8 reserved flagged", err_pulse[3], 1);
    step(1, P_LMR, 2, 13'h005);
    chk("R7 bad select flagged", err_pulse[6], 1);
    chk("R7 ext untouched", mr_ext, 13'h008);

    // R3 / R11
    step(1, P_ACT, 1, 13'h1ABC);
    chk("R3 bank 1 open", bank_open, 4'b0010);
    chk("R3 row reported", cmd_row, 13'h1ABC);
    step(1, P_ACT, 1, 13'h0005);
    chk("R11 reopen flagged", err_pulse[1], 1);
    chk("R11 row kept", bank_row[25:13], 13'h1ABC);

    // R9: terminate rules
    step(1, P_RD, 1, 13'h005);
    chk("R4 column", cmd_col, 5);
    step(1, P_BST, 0, 0);
    chk("R9 legal terminate", err_pulse[2], 0);
    step(1, P_BST, 0, 0);
    chk("R9 terminate with no burst", err_pulse[2], 1);
    step(1, P_RD, 2, 0);
    chk("R11 read closed bank", err_pulse[0], 1);

    // R4: auto-precharge closes after BURST_LEN/2
    step(1, P_RD, 1, 13'h407);
    chk("R4 ap reported", cmd_ap, 1);
    chk("R4 still open at cmd", bank_open[1], 1);
    step(1, P_BST, 0, 0);
    chk("R9 terminate in ap read", err_pulse[2], 1);
    chk("R4 still open one cycle on", bank_open[1], 1);
    step(1, P_NOP, 0, 0);
    chk("R4 closed at burst end", bank_open[1], 0);

    step(1, P_ACT, 0, 13'h0003);
    step(1, P_WR, 0, 13'h001);
    step(1, P_BST, 0, 0);
    chk("R9 terminate in write", err_pulse[2], 1);

    // R5
    step(1, P_ACT, 1, 13'h0011);
    step(1, P_ACT, 2, 13'h0022);
    step(1, P_PRE, 0, 13'h000);
    chk("R5 single precharge", bank_open, 4'b0110);
    step(1, P_PRE, 1, 13'h400);
    chk("R5 all precharge", bank_open, 4'b0000);

    // R6
    step(0, P_ACT, 3, 13'h0044);
    chk("R6 cke low flagged", err_pulse[5], 1);
    chk("R6 reported as NOP", cmd_code, 0);
    chk("R6 nothing opened", bank_open, 0);
    step(0, P_REF, 0, 0);
    chk("R6 self refresh code", cmd_code, 7);
    chk("R6 self refresh no error", err_pulse, 0);
    step(1, P_REF, 0, 0);
    chk("R1 auto refresh code", cmd_code, 6);

    step(1, P_ACT, 3, 13'h0099);
    step(1, P_NOP, 1, 13'h1FFF);
    step(1, P_DES, 0, 0);
    chk("R2 state kept over NOPs", bank_open, 4'b1000);
    chk("R12 sticky has all bits", err_sticky, 7'h7F);

    // random command stream
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  p;
      logic [12:0] a;
      int r;
      r = $urandom_range(0, 15);
      case (r)
        0, 1, 2: p = P_ACT;
        3, 4:    p = P_RD;
        5:       p = P_WR;
        6:       p = P_BST;
        7:       p = P_PRE;
        8:       p = P_LMR;
        9:       p = P_REF;
        10:      p = P_DES;
        default: p = P_NOP;
      endcase
      a = 13'($urandom);
      if ($urandom_range(0, 1) == 0) a[9:2] = 8'h08;
      step($urandom_range(0, 15) != 0, p, 2'($urandom), a);
    end

    finish_run();
  end

endmodule